// File: doc/BRIEF.md
# Start-Bit Framed Serial Segment Latch

This block receives the segment pattern for a 35-output display driver over two wires, a serial clock and a serial data line. Both wires are synchronised into a fast system clock domain, and the edges of the serial clock are recovered there. Each frame opens with a single marker bit of value 1. Exactly 35 data bits follow it. The marker moves along an internal shift chain as bits arrive. When it leaves the far end of the chain, the received word is copied into a parallel display register. The chain is then wiped on the following falling serial clock edge, which makes it ready for the next frame.

No latch or enable pin is needed, because the marker alone decides when a frame is complete. The block has no serial output, so it cannot be chained with others. The display register holds its value between frames. A one-cycle strobe marks every update. A host refreshes a multiplexed display by sending one frame per digit slot, with the serial clock idle low between frames.

Top module: `sfl_frame_latch`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), `seg_q` is all zeros and `upd_pulse` is low. A reset in the middle of a frame discards the partial frame, and a complete frame sent after it is received correctly.
- R2: A bit is taken from `ser_dat` only at a rising edge of `ser_clk`, after both lines pass through the two-stage synchroniser. Changes of `ser_dat` while `ser_clk` is steady, and falling edges of `ser_clk`, move no bit.
- R3: A frame is a 1 marker followed by 35 data bits. On the 36th rising edge, `seg_q` takes the data, with the first data bit in `seg_q[34]` and the last in `seg_q[0]`. An all-zero data frame still performs the transfer.
- R4: `seg_q` and `upd_pulse` change on the third rising system clock edge after `ser_clk` rises at the pin, provided the input changes between system clock edges.
- R5: `seg_q` changes only at a frame transfer. It holds its value while a later frame is still arriving, including after 35 of that frame's 36 bits.
- R6: On the first falling `ser_clk` edge after a transfer, the shift chain is cleared. A frame with all-ones data therefore leaves no stale 1 that could end the next frame early.
- R7: `upd_pulse` is high for exactly one system clock cycle per transfer, in the cycle where `seg_q` first shows the new word.
- R8: Zero bits clocked in before a marker are ignored. The frame starts at the first 1 received while the chain is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous, idles low |
| ser_dat | input | 1 | Serial data, sampled at rising serial clock |
| seg_q | output | 35 | Display register, one bit per segment output |
| upd_pulse | output | 1 | One-cycle strobe on every display update |

## Verification
A corrupted shift chain becomes visible at the ports when it ends a frame too early or too late. The strobe then fires after the wrong number of serial bits, and `seg_q` carries a shifted or stale word. This shows within the frame in which the fault occurs. A chain that is not cleared shows up one frame later, as a premature strobe after the marker of the next frame. A fault in the edge detector shows up as a wrong latency in system clock cycles, or as bits moved by data toggles or falling edges. The latency fault appears at the first transfer after it.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   // Serial events recovered in the system clock domain
   typedef struct packed {
      logic rise;   // serial clock 0->1 seen this cycle
      logic fall;   // serial clock 1->0 seen this cycle
      logic dat;    // synchronised serial data
   } sfl_event_t;
endpackage

// File: rtl/sfl_sync_edge.sv
module sfl_sync_edge
   import sfl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_clk_i,
   input  logic       ser_dat_i,
   output sfl_event_t ev_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sfl_sync_edge: SYNC_STAGES must be at least 2");
   end

   logic [LAST:0] clk_sh;
   logic [LAST:0] dat_sh;
   logic          clk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sh   <= '0;
         dat_sh   <= '0;
         clk_prev <= 1'b0;
      end else begin
         clk_sh   <= {clk_sh[LAST-1:0], ser_clk_i};
         dat_sh   <= {dat_sh[LAST-1:0], ser_dat_i};
         clk_prev <= clk_sh[LAST];
      end
   end

   always_comb begin
      ev_o.rise = clk_sh[LAST] & ~clk_prev;
      ev_o.fall = ~clk_sh[LAST] & clk_prev;
      ev_o.dat  = dat_sh[LAST];
   end

   // A detected rise cannot repeat in the next cycle
   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_o.rise |=> !ev_o.rise);   // R2
endmodule

// File: rtl/sfl_shift_chain.sv
module sfl_shift_chain
   import sfl_pkg::*;
#(
   parameter int NUM_SEG = 35
) (
   input  logic               clk,
   input  logic               rst_n,
   input  sfl_event_t         ev_i,
   output logic               xfer_o,
   output logic [NUM_SEG-1:0] word_o
);
   localparam int TOP = NUM_SEG - 1;

   if (NUM_SEG < 2) begin : g_bad_width
      $error("sfl_shift_chain: NUM_SEG must be at least 2");
   end

   logic [TOP:0] chain_q;
   logic         ctl_q;    // marker has left the chain, clear pending
   logic [TOP:0] shifted;

   assign shifted = {chain_q[TOP-1:0], ev_i.dat};
   assign xfer_o  = ev_i.rise & chain_q[TOP];
   assign word_o  = shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         ctl_q   <= 1'b0;
      end else if (ev_i.rise) begin
         chain_q <= shifted;
         if (chain_q[TOP]) ctl_q <= 1'b1;
      end else if (ev_i.fall && ctl_q) begin
         chain_q <= '0;
         ctl_q   <= 1'b0;
      end
   end

   AST_MARK_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i.rise && chain_q[TOP]) |=> ctl_q);   // R3
   AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i.fall && ctl_q) |=> (chain_q == '0 && !ctl_q));   // R6
   AST_FALL_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_i.rise && !ctl_q) |=> $stable(chain_q));   // R2
endmodule

// File: rtl/sfl_disp_reg.sv
module sfl_disp_reg #(
   parameter int NUM_SEG       = 35,
   parameter bit FIRST_BIT_MSB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xfer_i,
   input  logic [NUM_SEG-1:0] word_i,
   output logic [NUM_SEG-1:0] seg_o,
   output logic               upd_o
);
   logic [NUM_SEG-1:0] mapped;

   if (FIRST_BIT_MSB) begin : g_msb_first
      assign mapped = word_i;
   end else begin : g_lsb_first
      for (genvar i = 0; i < NUM_SEG; i++) begin : g_rev
         assign mapped[i] = word_i[NUM_SEG-1-i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_o <= '0;
         upd_o <= 1'b0;
      end else begin
         upd_o <= xfer_i;
         if (xfer_i) seg_o <= mapped;
      end
   end

   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);   // R7
endmodule

// File: rtl/sfl_frame_latch.sv
module sfl_frame_latch
   import sfl_pkg::*;
#(
   parameter int NUM_SEG       = 35,
   parameter int SYNC_STAGES   = 2,
   parameter bit FIRST_BIT_MSB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_dat,
   output logic [NUM_SEG-1:0] seg_q,
   output logic               upd_pulse
);
   sfl_event_t         ev;
   logic               xfer;
   logic [NUM_SEG-1:0] word;

   sfl_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
      .ev_o(ev));

   sfl_shift_chain #(.NUM_SEG(NUM_SEG)) u_chain (
      .clk(clk), .rst_n(rst_n), .ev_i(ev), .xfer_o(xfer), .word_o(word));

   sfl_disp_reg #(.NUM_SEG(NUM_SEG), .FIRST_BIT_MSB(FIRST_BIT_MSB)) u_disp (
      .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .word_i(word),
      .seg_o(seg_q), .upd_o(upd_pulse));

   AST_SEG_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_q != $past(seg_q)) |-> upd_pulse);   // R5
   AST_RESET_STATE: assert property (@(posedge clk)
      !rst_n |-> (seg_q == '0 && !upd_pulse));   // R1
endmodule

// File: tb/sim_sfl_frame_latch.sv
module sim_sfl_frame_latch;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;   // system cycles per serial half period
   localparam int NS         = 35;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ser_clk = 1'b0;
   logic          ser_dat = 1'b0;
   logic [NS-1:0] seg_q;
   logic          upd_pulse;

   int n_chk = 0;
   int n_bad = 0;
   int strobes = 0;
   int wide = 0;
   logic upd_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfl_frame_latch u0 (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .seg_q(seg_q), .upd_pulse(upd_pulse));

   always @(negedge clk) begin
      if (upd_pulse) strobes <= strobes + 1;
      if (upd_pulse && upd_prev) wide <= wide + 1;
      upd_prev <= upd_pulse;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      ser_dat = b;
      wait_n(HALF);
      ser_clk = 1'b1;
      wait_n(HALF);
      ser_clk = 1'b0;
   endtask

   task automatic send_frame(input logic [NS-1:0] d);
      send_bit(1'b1);
      for (int i = NS-1; i >= 0; i--) send_bit(d[i]);
      wait_n(HALF);
   endtask

   task automatic t_reset();
      chk("R1 seg after reset", seg_q, 0);
      chk("R1 strobe after reset", upd_pulse, 0);
   endtask

   task automatic t_basic();
      int s0 = strobes;
      send_frame(35'h5_1234_ABCD);
      chk("R3 basic word", seg_q, 35'h5_1234_ABCD);
      chk("R7 one strobe", strobes - s0, 1);
      chk("R7 strobe width", wide, 0);
   endtask

   task automatic t_latency();
      logic [NS-1:0] d = 35'h2_F0F0_0F0F;
      int n = 0;
      send_bit(1'b1);
      for (int i = NS-1; i >= 1; i--) send_bit(d[i]);
      ser_dat = d[0];
      wait_n(HALF);
      ser_clk = 1'b1;
      while (!upd_pulse && n < 10) begin
         @(negedge clk);
         n++;
      end
      chk("R4 latency cycles", n, 3);
      chk("R4 word at strobe", seg_q, d);
      wait_n(HALF);
      ser_clk = 1'b0;
      wait_n(HALF);
   endtask

   task automatic t_hold();
      logic [NS-1:0] d = 35'h1_5555_AAAA;
      logic [NS-1:0] old = seg_q;
      int s0 = strobes;
      send_bit(1'b1);
      for (int i = NS-1; i >= 1; i--) send_bit(d[i]);
      wait_n(HALF);
      chk("R5 held during frame", seg_q, old);
      chk("R5 no early strobe", strobes - s0, 0);
      send_bit(d[0]);
      wait_n(HALF);
      chk("R5 updated at end", seg_q, d);
   endtask

   task automatic t_clear();
      logic [NS-1:0] d = 35'h6_0F0F_3C3C;
      int s0;
      send_frame('1);
      chk("R3 all ones word", seg_q, {NS{1'b1}});
      s0 = strobes;
      send_bit(1'b1);
      wait_n(HALF);
      chk("R6 no premature transfer", strobes - s0, 0);
      chk("R6 seg unchanged", seg_q, {NS{1'b1}});
      for (int i = NS-1; i >= 0; i--) send_bit(d[i]);
      wait_n(HALF);
      chk("R6 next frame word", seg_q, d);
      chk("R6 one strobe", strobes - s0, 1);
   endtask

   task automatic t_lead();
      logic [NS-1:0] d = 35'h3_1357_9BDF;
      for (int i = 0; i < 7; i++) send_bit(1'b0);
      send_frame(d);
      chk("R8 leading zeros ignored", seg_q, d);
   endtask

   task automatic t_ignore();
      logic [NS-1:0] d = 35'h4_8421_1248;
      int s0 = strobes;
      send_bit(1'b1);
      for (int i = NS-1; i >= 20; i--) send_bit(d[i]);
      for (int k = 0; k < 10; k++) begin
         ser_dat = ~ser_dat;
         wait_n(HALF);
      end
      for (int i = 19; i >= 0; i--) send_bit(d[i]);
      wait_n(HALF);
      chk("R2 data toggles ignored", seg_q, d);
      chk("R2 single strobe", strobes - s0, 1);
   endtask

   task automatic t_zero();
      int s0 = strobes;
      send_frame('0);
      chk("R3 zero frame word", seg_q, 0);
      chk("R7 zero frame strobe", strobes - s0, 1);
   endtask

   task automatic t_reset_mid();
      logic [NS-1:0] d = 35'h7_ACE1_0246;
      send_bit(1'b1);
      for (int i = 0; i < 20; i++) send_bit(1'b1);
      rst_n = 1'b0;
      wait_n(3);
      chk("R1 seg in mid reset", seg_q, 0);
      rst_n = 1'b1;
      wait_n(3);
      send_frame(d);
      chk("R1 frame after reset", seg_q, d);
   endtask

   initial begin
      wait_n(4);
      t_reset();
      rst_n = 1'b1;
      wait_n(4);
      t_basic();
      t_latency();
      t_hold();
      t_clear();
      t_lead();
      t_ignore();
      t_zero();
      t_reset_mid();
      chk("R7 strobe width overall", wide, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule